// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block guards software against both hanging and running away. A 7-bit downcounter is stepped by a two-stage divider: a fixed power-of-two stage (4096 by default) followed by a selectable divide-by-1, 2, 4 or 8. Once software has armed the watchdog, a reset request goes out in any of three cases. The first is the count falling out of its upper half. The second is a reload value that is already in the lower half. The third is a reload made too early, while the count is still above a programmable window value.

The count first enters the last step before timeout when it reaches 0x40. At that point the block raises a sticky warning flag. Software can route this flag to a level interrupt, which gives it a final chance to reload the counter. Software reaches the block through a small register interface: a write strobe with address and data, and a read port that returns its data one cycle after the address. Arming and the interrupt enable can only be set; nothing but the system reset clears them.

Top module: `win_wdog`

## Requirements
- R1: With select value s (0..3) in configuration bits 8:7, the counter decrements once every 2^(FIX_LOG2+s) clock cycles. The first decrement after a control write lands exactly that many clock edges after the write edge.
- R2: After reset, the control register reads 0x07F (count 0x7F, not armed), the configuration register reads 0x07F (window 0x7F, select 0, interrupt enable off), status reads 0, and irq and rst_req are low.
- R3: A control write with bit 7 set arms the watchdog. A later control write with bit 7 clear leaves it armed, and control readback bit 7 stays 1.
- R4: While armed, the decrement from 0x40 to 0x3F makes rst_req high for exactly one cycle, starting at that decrement's edge.
- R5: A control write whose count bits 6:0 are below 0x40 pulses rst_req at the write edge when the watchdog is armed or is being armed by that same write.
- R6: When the watchdog is already armed, a control write while the current count is above the window (configuration bits 6:0) pulses rst_req. A write while the count is equal to or below the window does not.
- R7: While the watchdog is not armed, the counter still runs and wraps from 0x00 to 0x7F, and rst_req stays low.
- R8: A control write restarts the prescaler phase, so partial progress toward the next decrement is discarded.
- R9: The warning flag (status bit 0) is set when the count steps from 0x41 to 0x40, whether or not the interrupt is enabled. If a status write clearing the flag lands in that same cycle, the flag is still set.
- R10: A status write with bit 0 equal to 0 clears the flag. A status write with bit 0 equal to 1 leaves it unchanged.
- R11: Configuration bit 9 enables the interrupt. Writing 0 there does not clear it. irq is high from the edge after which both the flag and the enable are 1.
- R12: The address map is: 0 control {armed bit 7, count bits 6:0}; 1 configuration {enable bit 9, select bits 8:7, window bits 6:0}; 2 status {flag bit 0}. rd_data returns the addressed register one cycle after rd_addr is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address of the write |
| wr_data | input | 10 | Write data |
| rd_addr | input | 2 | Register address of the read |
| rd_data | output | 10 | Read data, registered |
| irq | output | 1 | Early-warning interrupt, level |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The flag can be set by hardware and cleared by software in the same cycle. To provoke this, the bench loads 0x41 with the divider at its shortest setting. It then times a status clear so that its write edge is the exact edge on which the count reaches 0x40. Readback must show the flag still set, and a later isolated clear must empty it. A second collision is a reload arriving while the count sits exactly at the window value, next to one a single step above it. The first must not raise rst_req and the second must.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int CNT_W   = 7;
  localparam int PSEL_W  = 2;
  localparam int DATA_W  = 10;
  localparam int ADDR_W  = 2;

  localparam int CTRL_ARM_BIT  = 7;
  localparam int CFG_PSEL_LSB  = 7;
  localparam int CFG_IEN_BIT   = 9;
  localparam int STAT_FLAG_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
  parameter int FIX_LOG2 = 12,
  parameter int PSEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam int MAX_SH = (2 ** PSEL_W) - 1;
  localparam int PRE_W  = FIX_LOG2 + MAX_SH;

  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] limit;

  // 2^(FIX_LOG2+psel)-1 as an all-ones word shifted down
  assign limit = {PRE_W{1'b1}} >> (MAX_SH - int'(psel));
  assign tick  = (phase >= limit);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= '0;
    end else if (tick) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/wwd_core.sv
module wwd_core #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ctrl_wr,
  input  logic             wr_arm,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [CNT_W-1:0] window,
  input  logic             cfg_wr,
  input  logic             wr_ien,
  input  logic             stat_wr,
  input  logic             wr_flag,
  output logic [CNT_W-1:0] count,
  output logic             armed,
  output logic             flag,
  output logic             irq_en,
  output logic             irq,
  output logic             rst_req
);
  localparam logic [CNT_W-1:0] EDGE_VAL = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] WARN_PRE = EDGE_VAL + CNT_W'(1);

  logic armed_d, flag_d, ien_d;
  logic low_load, early_load, timeout, warn_hit;

  always_comb begin
    armed_d    = armed | (ctrl_wr & wr_arm);
    ien_d      = irq_en | (cfg_wr & wr_ien);
    low_load   = ctrl_wr && armed_d && !wr_cnt[CNT_W-1];
    early_load = ctrl_wr && armed && (count > window);
    timeout    = !ctrl_wr && tick && armed && (count == EDGE_VAL);
    warn_hit   = !ctrl_wr && tick && (count == WARN_PRE);
    if (warn_hit) begin
      flag_d = 1'b1;
    end else if (stat_wr && !wr_flag) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '1;
      armed   <= 1'b0;
      flag    <= 1'b0;
      irq_en  <= 1'b0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        count <= wr_cnt;
      end else if (tick) begin
        count <= count - 1'b1;
      end
      armed   <= armed_d;
      flag    <= flag_d;
      irq_en  <= ien_d;
      irq     <= flag_d & ien_d;
      rst_req <= low_load | early_load | timeout;
    end
  end
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import wwd_pkg::*;
#(
  parameter int FIX_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              rst_req
);
  logic              ctrl_wr, cfg_wr, stat_wr, tick;
  logic [CNT_W-1:0]  count, window;
  logic [PSEL_W-1:0] psel;
  logic              armed, flag, irq_en;

  assign ctrl_wr = wr_en && (wr_addr == SEL_CTRL);
  assign cfg_wr  = wr_en && (wr_addr == SEL_CFG);
  assign stat_wr = wr_en && (wr_addr == SEL_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      window <= '1;
      psel   <= '0;
    end else if (cfg_wr) begin
      window <= wr_data[CNT_W-1:0];
      psel   <= wr_data[CFG_PSEL_LSB +: PSEL_W];
    end
  end

  wwd_prescaler #(.FIX_LOG2(FIX_LOG2), .PSEL_W(PSEL_W)) u_pre (
    .clk(clk), .rst(rst), .restart(ctrl_wr), .psel(psel), .tick(tick)
  );

  wwd_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick),
    .ctrl_wr(ctrl_wr), .wr_arm(wr_data[CTRL_ARM_BIT]), .wr_cnt(wr_data[CNT_W-1:0]),
    .window(window),
    .cfg_wr(cfg_wr), .wr_ien(wr_data[CFG_IEN_BIT]),
    .stat_wr(stat_wr), .wr_flag(wr_data[STAT_FLAG_BIT]),
    .count(count), .armed(armed), .flag(flag), .irq_en(irq_en),
    .irq(irq), .rst_req(rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        SEL_CTRL: rd_data <= DATA_W'({armed, count});
        SEL_CFG:  rd_data <= DATA_W'({irq_en, psel, window});
        SEL_STAT: rd_data <= DATA_W'(flag);
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_wr,
  input logic [CNT_W-1:0] count,
  input logic             armed,
  input logic             flag,
  input logic             irq_en,
  input logic             irq,
  input logic             rst_req
);
  assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  assert_arm_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);

  assert_ien_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    irq_en |=> irq_en);

  assert_irq_src_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && irq_en));

  assert_req_armed_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> armed);

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctrl_wr) && (count != $past(count))) |-> (count == CNT_W'($past(count) - 1'b1)));
endmodule

bind win_wdog wwd_checker #(.CNT_W(wwd_pkg::CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .count(count), .armed(armed),
  .flag(flag), .irq_en(irq_en), .irq(irq), .rst_req(rst_req)
);

// File: tb/win_wdog_test.sv
module win_wdog_test;
  localparam int FIX = 2;
  localparam int VW  = 23;  // {is_write, addr[1:0], data[9:0], expect[9:0]}
  localparam int NV  = 11;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 2'd1, 10'h1B0, 10'h000},  // cfg: select 3, window 0x30
    {1'b0, 2'd1, 10'h000, 10'h1B0},  // R12 cfg readback
    {1'b1, 2'd0, 10'h055, 10'h000},  // ctrl: count 0x55, not armed
    {1'b0, 2'd0, 10'h000, 10'h055},  // R12 ctrl readback
    {1'b1, 2'd1, 10'h3B0, 10'h000},  // enable interrupt
    {1'b0, 2'd1, 10'h000, 10'h3B0},  // R11 enable visible
    {1'b1, 2'd1, 10'h0A5, 10'h000},  // enable bit 0, select 1, window 0x25
    {1'b0, 2'd1, 10'h000, 10'h2A5},  // R11 enable sticky
    {1'b0, 2'd2, 10'h000, 10'h000},  // R12 status empty
    {1'b1, 2'd2, 10'h001, 10'h000},  // write 1 to flag
    {1'b0, 2'd2, 10'h000, 10'h000}   // R10 no effect
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [9:0] rd_data;
  logic       irq, rst_req;
  int checks = 0, fails = 0, pulses = 0;

  always #10 clk = ~clk;

  win_wdog #(.FIX_LOG2(FIX)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
  );

  always @(negedge clk) if (rst_req) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [9:0] exp, input string req);
    rd_addr = a;
    @(negedge clk);
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic wait_rd(input int d, input logic [9:0] exp, input string req);
    repeat (d) @(negedge clk);
    rd(2'd0, exp, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int p0;
    do_reset();
    // R2 reset state
    chk(rst_req == 1'b0 && irq == 1'b0, "R2 outputs", {irq, rst_req}, 0);
    rd(2'd0, 10'h07F, "R2 ctrl");
    rd(2'd1, 10'h07F, "R2 cfg");
    rd(2'd2, 10'h000, "R2 status");

    // R12 / R11 / R10 table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][22]) wr(VEC[i][21:20], VEC[i][19:10]);
      else rd(VEC[i][21:20], VEC[i][9:0], "R12 table");
    end

    // R1 decrement period
    do_reset();
    wr(2'd1, 10'h080);
    wr(2'd0, 10'h07F); wait_rd(7, 10'h07F, "R1 s1 before");
    wr(2'd0, 10'h07F); wait_rd(8, 10'h07E, "R1 s1 at");
    wr(2'd1, 10'h180);
    wr(2'd0, 10'h07F); wait_rd(31, 10'h07F, "R1 s3 before");
    wr(2'd0, 10'h07F); wait_rd(64, 10'h07D, "R1 s3 two");
    // R8 restart
    wr(2'd1, 10'h000);
    wr(2'd0, 10'h07F); repeat (2) @(negedge clk);
    wr(2'd0, 10'h07F); wait_rd(3, 10'h07F, "R8 restart");

    // R7 unarmed wrap
    do_reset();
    p0 = pulses;
    wr(2'd0, 10'h000);
    chk(rst_req == 1'b0, "R7 low write unarmed", rst_req, 0);
    wait_rd(4, 10'h07F, "R7 wrap");
    chk(pulses == p0, "R7 no request", pulses - p0, 0);

    // R4 timeout and R11 irq timing
    do_reset();
    wr(2'd1, 10'h200);
    wr(2'd0, 10'h0C1);
    for (int d = 1; d <= 10; d++) begin
      @(negedge clk);
      chk(rst_req == (d == 8), "R4 timeout pulse", rst_req, (d == 8));
      if (d == 3) chk(irq == 1'b0, "R11 irq before", irq, 0);
      if (d == 4) chk(irq == 1'b1, "R11 irq on flag", irq, 1);
    end

    // R5 low reload
    do_reset();
    wr(2'd0, 10'h0BF);
    chk(rst_req == 1'b1, "R5 low reload", rst_req, 1);
    @(negedge clk);
    chk(rst_req == 1'b0, "R4 single cycle", rst_req, 0);

    // R6 window
    do_reset();
    wr(2'd1, 10'h050);
    wr(2'd0, 10'h0D0); chk(rst_req == 1'b0, "R6 arming write", rst_req, 0);
    wr(2'd0, 10'h0D0); chk(rst_req == 1'b0, "R6 equal window", rst_req, 0);
    wr(2'd0, 10'h0D1); chk(rst_req == 1'b0, "R6 equal again", rst_req, 0);
    wr(2'd0, 10'h0D1); chk(rst_req == 1'b1, "R6 above window", rst_req, 1);

    // R9 / R10 flag
    do_reset();
    wr(2'd0, 10'h041);
    repeat (3) @(negedge clk);
    wr(2'd2, 10'h000);
    rd(2'd2, 10'h001, "R9 set wins");
    chk(irq == 1'b0, "R9 irq off", irq, 0);
    wr(2'd2, 10'h001); rd(2'd2, 10'h001, "R10 write one");
    wr(2'd2, 10'h000); rd(2'd2, 10'h000, "R10 clear");

    // R3 armed sticky
    do_reset();
    wr(2'd0, 10'h0FF);
    wr(2'd0, 10'h07F);
    rd(2'd0, 10'h0FF, "R3 sticky");
    do_reset();
    rd(2'd0, 10'h07F, "R3 reset clears");

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule